// File: doc/BRIEF.md
# Size-Keyed Dummy Bus Responder

This block stands in for a peripheral that is absent from a chip build. It answers every access that lands in its address window, so software that probes the window always gets a response and never stalls. The data it returns depends on the width of the access, not on its address. It keeps one stored return value for each of the widths 1, 2, 4 and 8 bytes. After reset all four hold all ones, so a read of any width returns -1.

The behaviour is fixed at build time by parameters. In update mode a write replaces the stored value for its own width only; with update mode off, writes complete and their data is discarded. In bad-address mode the block claims every access, whatever its address, and answers each one with an error. The zero-fill mode decides how a read of an unsupported size is answered: with zeros, or with an error. The report mode gives a one-cycle strobe for each accepted access, carrying the address, size, direction and write data.

The bus uses a valid/ready handshake. The requester holds its request steady until it sees `rsp_ready`, and the transfer ends at the clock edge where valid and ready are both high. Every accepted access takes the same fixed number of cycles. An address outside the window is never claimed, so the fabric's own default response deals with it.

Top module: `dummy_resp`

## Requirements
- R1: After reset the stored values are the init parameters (all ones by default). A read of size 1, 2, 4 or 8 then returns 0xFF, 0xFFFF, 0xFFFFFFFF or all ones respectively, with `rsp_err` low.
- R2: A read of size 1, 2, 4 or 8 returns the stored value for that width on the low byte lanes (byte 0 in bits 7:0), and every higher lane is zero.
- R3: In update mode, a write of size N (N = 1, 2, 4 or 8) loads the low 8N bits of `req_wdata` into the N-byte value and completes with `rsp_err` low. The other three values are unchanged, and a read of width N that immediately follows the write returns the new value.
- R4: With update mode off, a write completes with `rsp_err` low and no stored value changes.
- R5: In bad-address mode, every access at any address is claimed. Reads and writes both complete with `rsp_err` high, and `rsp_rdata` is zero.
- R6: A read whose size is not 1, 2, 4 or 8 returns zero data with `rsp_err` low when zero-fill mode is on. When zero-fill mode is off, it completes with `rsp_err` high and zero data.
- R7: A write whose size is not 1, 2, 4 or 8 changes no stored value. It completes with `rsp_err` high if update or report mode is on, and with `rsp_err` low otherwise.
- R8: `rsp_ready` is low after reset. For an accepted request it rises exactly DELAY clock edges (DELAY ≥ 1) after the capture edge. It stays high until the edge where `req_valid` is also high, and it is low in the cycle after that edge.
- R9: With report mode on, `rpt_valid` is high for exactly one cycle, the cycle after each capture edge. It carries the address, size and direction, and `rpt_data` holds the write data masked to min(size, 8) bytes (zero for reads). With report mode off, `rpt_valid` never rises.
- R10: Outside bad-address mode, a request is claimed only when BASE ≤ address < BASE + WIN. For any other address, `rsp_ready` never rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present, held until the handshake |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_size | input | 4 | Access size in bytes (0 to 15) |
| req_wdata | input | 64 | Write data, little-endian lanes |
| rsp_ready | output | 1 | Response valid; transfer ends when req_valid is also high |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 64 | Read data, little-endian lanes |
| rpt_valid | output | 1 | One-cycle access report strobe |
| rpt_write | output | 1 | Reported direction |
| rpt_addr | output | AW | Reported address |
| rpt_size | output | 4 | Reported size |
| rpt_data | output | 64 | Reported write data, masked to the size |

## Verification
Two events share one capture edge: the update of a stored value and the report strobe for that write. On top of that, the next request can be captured right after a handshake edge. The bench provokes both together. It presents a read of the same width at the very negedge after each write's handshake, so the read is captured at the first edge where the responder is idle again. It judges the pair by three things: the read returns the freshly written value, the report for the write carries the masked write data, and reads of the other three widths still return their old values.

// File: rtl/dummy_resp_pkg.sv
package dummy_resp_pkg;

    typedef enum logic [2:0] {
        SZ_BYTE = 3'd0,
        SZ_HALF = 3'd1,
        SZ_WORD = 3'd2,
        SZ_DBL  = 3'd3,
        SZ_ODD  = 3'd4
    } size_cls_e;

    typedef struct packed {
        logic        err;
        logic [63:0] data;
    } rsp_t;

    function automatic size_cls_e classify(input logic [3:0] s);
        case (s)
            4'd1:    return SZ_BYTE;
            4'd2:    return SZ_HALF;
            4'd4:    return SZ_WORD;
            4'd8:    return SZ_DBL;
            default: return SZ_ODD;
        endcase
    endfunction

    function automatic logic [1:0] slot_of(input size_cls_e c);
        logic [2:0] b;
        b = c;
        return b[1:0];
    endfunction

    // Mask covering min(s, 8) bytes on the low lanes.
    function automatic logic [63:0] byte_mask(input logic [3:0] s);
        if (s >= 4'd8) return '1;
        return (64'd1 << {s[2:0], 3'b000}) - 64'd1;
    endfunction

endpackage

// File: rtl/dr_window.sv
module dr_window #(
    parameter int                 AW      = 16,
    parameter logic [AW-1:0]      BASE    = '0,
    parameter logic [AW-1:0]      WIN     = 16'h0040,
    parameter bit                 BAD_ALL = 1'b0
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    localparam logic [AW:0] LO = {1'b0, BASE};
    localparam logic [AW:0] HI = {1'b0, BASE} + {1'b0, WIN};

    logic [AW:0] a_ext;
    assign a_ext = {1'b0, addr};

    generate
        if (BAD_ALL) begin : g_all
            assign hit = 1'b1;
        end else begin : g_range
            assign hit = (a_ext >= LO) && (a_ext < HI);
        end
    endgenerate
endmodule

// File: rtl/dr_store.sv
module dr_store #(
    parameter logic [63:0] INIT_B = '1,
    parameter logic [63:0] INIT_H = '1,
    parameter logic [63:0] INIT_W = '1,
    parameter logic [63:0] INIT_D = '1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [63:0] wdata,
    input  logic [1:0]  rd_sel,
    output logic [63:0] rd_val
);
    logic [3:0][63:0] val;

    for (genvar i = 0; i < 4; i++) begin : g_slot
        localparam int          W  = 8 << i;
        localparam logic [63:0] IV = (i == 0) ? INIT_B : (i == 1) ? INIT_H :
                                     (i == 2) ? INIT_W : INIT_D;
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)                              q <= IV[W-1:0];
            else if (wr_en && wr_sel == 2'(i))    q <= wdata[W-1:0];
        end
        if (W < 64) begin : g_pad
            assign val[i] = {{(64-W){1'b0}}, q};
        end else begin : g_full
            assign val[i] = q;
        end
    end

    assign rd_val = val[rd_sel];

    // R4 / R7: without a write enable no stored value moves
    a_r4_frozen: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(val));
    // R3: a write touches only its own slot
    a_r3_one_slot: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel != 2'd0) |=> $stable(val[0]));
endmodule

// File: rtl/dr_timer.sv
module dr_timer #(
    parameter int DELAY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic take,
    output logic busy,
    output logic ready
);
    localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                cnt  <= CW'(DELAY - 1);
            end
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else if (take) begin
            busy <= 1'b0;
        end
    end

    assign ready = busy && (cnt == '0);

    // R8: the handshake edge ends the response
    a_r8_ready_drop: assert property (@(posedge clk) disable iff (rst)
        (ready && take) |=> !ready);
    // R8: a pending access stays pending until answered
    a_r8_hold_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && !ready) |=> busy);
endmodule

// File: rtl/dummy_resp.sv
module dummy_resp #(
    parameter int            AW        = 16,
    parameter logic [AW-1:0] BASE      = 16'h0100,
    parameter logic [AW-1:0] WIN       = 16'h0040,
    parameter int            DELAY     = 3,
    parameter bit            BAD_ALL   = 1'b0,
    parameter bit            UPDATE    = 1'b1,
    parameter bit            ZERO_FILL = 1'b1,
    parameter bit            REPORT    = 1'b1,
    parameter logic [63:0]   INIT_B    = '1,
    parameter logic [63:0]   INIT_H    = '1,
    parameter logic [63:0]   INIT_W    = '1,
    parameter logic [63:0]   INIT_D    = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [3:0]    req_size,
    input  logic [63:0]   req_wdata,
    output logic          rsp_ready,
    output logic          rsp_err,
    output logic [63:0]   rsp_rdata,
    output logic          rpt_valid,
    output logic          rpt_write,
    output logic [AW-1:0] rpt_addr,
    output logic [3:0]    rpt_size,
    output logic [63:0]   rpt_data
);
    import dummy_resp_pkg::*;

    logic      hit, busy, capture, upd_en, odd;
    logic [1:0] sel;
    logic [63:0] stored;
    size_cls_e cls;
    rsp_t      rsp_d, rsp_q;

    dr_window #(.AW(AW), .BASE(BASE), .WIN(WIN), .BAD_ALL(BAD_ALL)) u_win (
        .addr(req_addr), .hit(hit));

    assign capture = req_valid && !busy && hit;
    assign cls     = classify(req_size);
    assign odd     = (cls == SZ_ODD);
    assign sel     = slot_of(cls);

    dr_timer #(.DELAY(DELAY)) u_tmr (
        .clk(clk), .rst(rst), .start(capture), .take(req_valid),
        .busy(busy), .ready(rsp_ready));

    always_comb begin
        rsp_d  = '0;
        upd_en = 1'b0;
        if (BAD_ALL) begin
            rsp_d.err = 1'b1;
        end else if (req_write) begin
            rsp_d.err = odd && (UPDATE || REPORT);
            upd_en    = capture && UPDATE && !odd;
        end else if (odd) begin
            rsp_d.err = !ZERO_FILL;
        end else begin
            rsp_d.data = stored;
        end
    end

    dr_store #(.INIT_B(INIT_B), .INIT_H(INIT_H), .INIT_W(INIT_W), .INIT_D(INIT_D)) u_st (
        .clk(clk), .rst(rst), .wr_en(upd_en), .wr_sel(sel),
        .wdata(req_wdata), .rd_sel(sel), .rd_val(stored));

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else if (capture) rsp_q <= rsp_d;
    end

    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            rpt_valid <= 1'b0;
            rpt_write <= 1'b0;
            rpt_addr  <= '0;
            rpt_size  <= '0;
            rpt_data  <= '0;
        end else begin
            rpt_valid <= capture && REPORT;
            if (capture) begin
                rpt_write <= req_write;
                rpt_addr  <= req_addr;
                rpt_size  <= req_size;
                rpt_data  <= req_write ? (req_wdata & byte_mask(req_size)) : '0;
            end
        end
    end

    // R9: one strobe per access
    a_r9_rpt_pulse: assert property (@(posedge clk) disable iff (rst)
        rpt_valid |=> !rpt_valid);
    // R10: an unclaimed address starts no access
    a_r10_unclaimed: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && !hit) |=> !busy);
    // R5: in fail-everything mode every answer is an error
    a_r5_bad_err: assert property (@(posedge clk) disable iff (rst)
        (rsp_ready && BAD_ALL) |-> (rsp_err && rsp_rdata == '0));
    // R9: a strobe only follows an accepted access
    a_r9_rpt_after_capture: assert property (@(posedge clk) disable iff (rst)
        rpt_valid |-> busy);
endmodule

// File: tb/dummy_resp_tb.sv
module dummy_resp_tb;
    localparam logic [15:0] BASE = 16'h0100;
    localparam logic [15:0] WIN  = 16'h0040;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        v_a = 0, v_b = 0, v_c = 0;
    logic        wr = 0;
    logic [15:0] addr = '0;
    logic [3:0]  sz = '0;
    logic [63:0] wd = '0;

    logic        a_rdy, a_err, a_rv, a_rw, b_rdy, b_err, b_rv, b_rw, c_rdy, c_err, c_rv, c_rw;
    logic [63:0] a_rd, a_pd, b_rd, b_pd, c_rd, c_pd;
    logic [15:0] a_pa, b_pa, c_pa;
    logic [3:0]  a_ps, b_ps, c_ps;

    dummy_resp #(.BASE(BASE), .WIN(WIN), .DELAY(3), .BAD_ALL(0), .UPDATE(1),
                 .ZERO_FILL(1), .REPORT(1)) u_dut (
        .clk(clk), .rst(rst), .req_valid(v_a), .req_write(wr), .req_addr(addr),
        .req_size(sz), .req_wdata(wd), .rsp_ready(a_rdy), .rsp_err(a_err),
        .rsp_rdata(a_rd), .rpt_valid(a_rv), .rpt_write(a_rw), .rpt_addr(a_pa),
        .rpt_size(a_ps), .rpt_data(a_pd));

    dummy_resp #(.BASE(BASE), .WIN(WIN), .DELAY(1), .BAD_ALL(1), .UPDATE(1),
                 .ZERO_FILL(1), .REPORT(0)) u_dut_bad (
        .clk(clk), .rst(rst), .req_valid(v_b), .req_write(wr), .req_addr(addr),
        .req_size(sz), .req_wdata(wd), .rsp_ready(b_rdy), .rsp_err(b_err),
        .rsp_rdata(b_rd), .rpt_valid(b_rv), .rpt_write(b_rw), .rpt_addr(b_pa),
        .rpt_size(b_ps), .rpt_data(b_pd));

    dummy_resp #(.BASE(BASE), .WIN(WIN), .DELAY(2), .BAD_ALL(0), .UPDATE(0),
                 .ZERO_FILL(0), .REPORT(0)) u_dut_plain (
        .clk(clk), .rst(rst), .req_valid(v_c), .req_write(wr), .req_addr(addr),
        .req_size(sz), .req_wdata(wd), .rsp_ready(c_rdy), .rsp_err(c_err),
        .rsp_rdata(c_rd), .rpt_valid(c_rv), .rpt_write(c_rw), .rpt_addr(c_pa),
        .rpt_size(c_ps), .rpt_data(c_pd));

    int errors = 0, checks = 0;
    int quiet_rpt = 0;

    always @(negedge clk) if (!rst && (b_rv || c_rv)) quiet_rpt++;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // results of the last access
    logic [63:0] r_data, r_pdata;
    logic        r_err, r_pw;
    logic [15:0] r_paddr;
    logic [3:0]  r_psize;
    int          r_cyc, r_rpt_n;

    // Called at a negedge. Leaves valid high after the handshake.
    task automatic acc(input int dev, input logic w, input logic [15:0] ad,
                       input logic [3:0] s, input logic [63:0] d);
        logic rdy, rv;
        wr = w; addr = ad; sz = s; wd = d;
        v_a = (dev == 0); v_b = (dev == 1); v_c = (dev == 2);
        r_cyc = 0; r_rpt_n = 0;
        do begin
            @(negedge clk);
            r_cyc++;
            rdy = (dev == 0) ? a_rdy : (dev == 1) ? b_rdy : c_rdy;
            rv  = (dev == 0) ? a_rv : 1'b0;
            if (rv) begin
                r_rpt_n++; r_pw = a_rw; r_paddr = a_pa; r_psize = a_ps; r_pdata = a_pd;
            end
        end while (!rdy && r_cyc < 40);
        r_data = (dev == 0) ? a_rd : (dev == 1) ? b_rd : c_rd;
        r_err  = (dev == 0) ? a_err : (dev == 1) ? b_err : c_err;
        @(negedge clk);
        rdy = (dev == 0) ? a_rdy : (dev == 1) ? b_rdy : c_rdy;
        chk("R8 ready low after handshake", 64'(rdy), 64'd0);
    endtask

    task automatic idle();
        v_a = 0; v_b = 0; v_c = 0;
        @(negedge clk);
    endtask

    function automatic logic [63:0] msk(input int i);
        return (i == 3) ? '1 : ((64'd1 << (8 << i)) - 64'd1);
    endfunction

    function automatic int idx_of(input logic [3:0] s);
        case (s)
            4'd1: return 0;
            4'd2: return 1;
            4'd4: return 2;
            4'd8: return 3;
            default: return -1;
        endcase
    endfunction

    logic [63:0] m [4];

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m[i] = msk(i);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R8 reset ready", {62'd0, a_rdy, c_rdy}, 64'd0);
        chk("R9 reset strobe", 64'(a_rv), 64'd0);

        // R1 R2 R6: read sweep over all sizes after reset
        for (int s = 0; s < 16; s++) begin
            int k;
            k = idx_of(4'(s));
            acc(0, 1'b0, BASE + 16'(s), 4'(s), '0);
            chk("R8 latency", 64'(r_cyc), 64'd3);
            chk(k >= 0 ? "R1 reset read" : "R6 zero fill", r_data, k >= 0 ? m[k] : 64'd0);
            chk("R6 read err", 64'(r_err), 64'd0);
            chk("R9 read report", {r_pdata, 32'(r_rpt_n), 16'(r_paddr), 8'(r_psize), 7'd0, r_pw},
                {64'd0, 32'd1, BASE + 16'(s), 8'(s), 8'd0});
        end
        idle();

        // R3 R9: write each width, read it back at once (back-to-back)
        for (int k = 0; k < 4; k++) begin
            logic [63:0] p;
            logic [3:0]  s;
            s = 4'(1 << k);
            p = 64'hF0E1_D2C3_B4A5_9687 ^ (64'h1357_9BDF_2468_ACE0 * 64'(k + 1));
            acc(0, 1'b1, BASE + 16'h10, s, p);
            chk("R3 write err", 64'(r_err), 64'd0);
            chk("R9 write report data", r_pdata, p & msk(k));
            chk("R9 write report dir", {62'd0, r_pw, 1'(r_rpt_n == 1)}, 64'd3);
            m[k] = p & msk(k);
            acc(0, 1'b0, BASE + 16'h11, s, '0);
            chk("R3 read back", r_data, m[k]);
            for (int j = 0; j < 4; j++) begin
                acc(0, 1'b0, BASE, 4'(1 << j), '0);
                chk("R3 others kept", r_data, m[j]);
            end
            idle();
        end

        // R7: odd write size with update on errs and changes nothing
        acc(0, 1'b1, BASE, 4'd3, 64'h0);
        chk("R7 odd write err (update on)", 64'(r_err), 64'd1);
        chk("R9 odd write report", r_pdata, 64'd0);
        acc(0, 1'b1, BASE, 4'd12, 64'h0);
        chk("R7 odd write err size 12", 64'(r_err), 64'd1);
        for (int j = 0; j < 4; j++) begin
            acc(0, 1'b0, BASE, 4'(1 << j), '0);
            chk("R7 values kept", r_data, m[j]);
        end
        idle();

        // R10: window edges
        begin
            logic [15:0] probe [3];
            logic seen;
            probe[0] = BASE - 16'd1; probe[1] = BASE + WIN; probe[2] = 16'hFFFF;
            for (int q = 0; q < 3; q++) begin
                wr = 0; addr = probe[q]; sz = 4'd4; v_a = 1; seen = 0;
                repeat (8) begin @(negedge clk); if (a_rdy) seen = 1; end
                chk("R10 unclaimed address", 64'(seen), 64'd0);
                idle();
            end
        end
        acc(0, 1'b0, BASE + WIN - 16'd1, 4'd2, '0);
        chk("R10 top of window claimed", r_data, m[1]);
        idle();

        // R4 R6 R7: plain configuration (no update, no zero fill, no report)
        acc(2, 1'b0, BASE, 4'd5, '0);
        chk("R8 latency plain", 64'(r_cyc), 64'd2);
        chk("R6 odd read err", {r_data[62:0], r_err}, 64'd1);
        acc(2, 1'b1, BASE, 4'd2, 64'h1234);
        chk("R4 write err", 64'(r_err), 64'd0);
        acc(2, 1'b0, BASE, 4'd2, '0);
        chk("R4 value kept", r_data, 64'hFFFF);
        acc(2, 1'b1, BASE, 4'd6, 64'h55);
        chk("R7 odd write err (modes off)", 64'(r_err), 64'd0);
        acc(2, 1'b0, BASE, 4'd8, '0);
        chk("R4 double kept", r_data, '1);
        idle();

        // R5: fail-everything mode, any address
        acc(1, 1'b0, BASE, 4'd4, '0);
        chk("R5 read err", {r_data[62:0], r_err}, 64'd1);
        acc(1, 1'b1, 16'hFFFF, 4'd8, 64'hABCD);
        chk("R5 write err", 64'(r_err), 64'd1);
        acc(1, 1'b0, 16'h0000, 4'd1, '0);
        chk("R5 far read err", {r_data[62:0], r_err}, 64'd1);
        idle();

        chk("R9 no strobe when report off", 64'(quiet_rpt), 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule